// File: doc/BRIEF.md
# Two-Wire LCD Segment Data Port with Readback

This block is the serial receive side of a multiplexed LCD segment driver. It watches an open-drain two-wire bus: a serial clock and a bidirectional data line, both already brought into the system clock domain. A transfer opens with a start condition. Next comes an 8-bit address byte, sent MSB first. Its upper seven bits must equal `0111` followed by the three strap pins. The lowest bit picks the direction.

In write direction, each data bit is shifted into a segment shift register of `REG_BITS` bits, and the device acknowledges every byte. Once a full block has arrived, the register can be copied into a display latch in one of two ways. It is copied on its own when the latch-enable input is high. Otherwise it is copied on a rising edge of latch-enable while the bus clock is high. In read direction, the register is sent back to the controller in the order it was written, and its contents are left unchanged.

The only bus output is a pull-low enable for an external open-drain data pad. The block reports nothing else.

Top module: `lcd_seg_port`

## Requirements
- R1: After reset the shift register and display latch are all zero and the data pull-low enable is inactive.
- R2: A start condition (data falls while the clock is high) begins a new address phase in any state, including in the middle of a byte. A stop condition (data rises while the clock is high) returns the block to idle.
- R3: The device acknowledges an address byte only when its upper seven bits equal `0111` followed by the straps (bit 3 = strap[2], bit 1 = strap[0]). When they differ, it pulls nothing on the ninth clock and ignores every bit until the next start.
- R4: In write direction, each rising clock edge shifts the data level into bit 0, and the older bits move toward the MSB. After 16 bytes, the first byte sent is therefore in bits 127:120.
- R5: In write direction, after each data byte the pull-low enable is asserted on the falling edge that ends the 8th bit. It is released on the falling edge that ends the 9th clock, so it is held for that whole clock.
- R6: With latch-enable high, the display latch takes the shift register as soon as the 128th data bit since the address has been shifted, and not before.
- R7: With latch-enable low, no automatic copy happens. A rising edge of latch-enable while the clock is high copies the shift register into the display latch.
- R8: When the bus is left open after a 128-bit block, the first clock after that block's acknowledge clock shifts nothing. Reception resumes on the following clock.
- R9: In read direction, the device presents bit 127−k as the k-th data bit, with the line low for 0 and released for 1. It drives each bit from the falling edge before that bit's clock. After 128 bits the shift register is unchanged.
- R10: In read direction, the pull-low enable is off during the ninth clock of every byte. A controller that leaves data high on that clock ends the read, and the device releases the bus until the next start.
- R11: The pull-low enable is never active in idle or during the address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level, synchronized |
| sda_i | input | 1 | Bus data level, synchronized (wired-AND of all drivers) |
| strap_i | input | 3 | Address strap bits |
| latch_en_i | input | 1 | High: automatic latch per block; rising edge with clock high: manual latch |
| sda_pull_o | output | 1 | Pull data line low when 1 |
| shift_o | output | REG_BITS | Segment shift register |
| disp_o | output | REG_BITS | Display latch |

## Verification
Bus events are found by comparing the inputs with a one-cycle registered copy. The pull-low enable and the shift register therefore change on the first clock edge that sees a bus clock edge. The display latch follows one cycle after the 128th shift, or one cycle after the latch-enable rise. The bench holds every bus phase for at least three system clocks and samples on falling system edges late in each phase, so every result has settled before it is read. It models the shift register bit by bit, including the bits that the bus clock rise inside a stop or repeated start shifts in. It also sweeps all 128 address values, checking the acknowledge against the strap setting.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_WSKIP, ST_RDAT, ST_RGAP
  } port_state_e;
endpackage

// File: rtl/lcd_seg_bus_sense.sv
module lcd_seg_bus_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/lcd_seg_engine.sv
module lcd_seg_engine
  import lcd_seg_pkg::*;
#(
  parameter int REG_BITS = 128,
  parameter logic [3:0] ADDR_FIXED = 4'b0111
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                sda_i,
  input  logic [2:0]          strap_i,
  output logic                pull_o,
  output logic                done_o,
  output logic [REG_BITS-1:0] sreg_o
);
  localparam int TW = $clog2(REG_BITS);

  port_state_e         state_q;
  logic [REG_BITS-1:0] sreg_q;
  logic [7:0]          addr_q;
  logic [3:0]          cnt_q;
  logic [TW-1:0]       tot_q;
  logic                pull_q, skip_q, done_q;
  logic                match;

  assign match = (addr_q[7:1] == {ADDR_FIXED, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      tot_q   <= '0;
      pull_q  <= 1'b0;
      skip_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        tot_q   <= '0;
        skip_q  <= 1'b0;
        pull_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (rise_i) begin
              addr_q <= {addr_q[6:0], sda_i};
              cnt_q  <= cnt_q + 4'd1;
            end else if (fall_i && cnt_q == 4'd8) begin
              cnt_q   <= '0;
              state_q <= match ? ST_AACK : ST_IDLE;
              pull_q  <= match;
            end
          end
          ST_AACK: if (fall_i) begin
            if (addr_q[0]) begin
              state_q <= ST_RDAT;
              pull_q  <= ~sreg_q[REG_BITS-1];
            end else begin
              state_q <= ST_WDAT;
              pull_q  <= 1'b0;
            end
          end
          ST_WDAT: begin
            if (rise_i) begin
              sreg_q <= {sreg_q[REG_BITS-2:0], sda_i};
              cnt_q  <= cnt_q + 4'd1;
              tot_q  <= tot_q + 1'b1;
              if (tot_q == TW'(REG_BITS - 1)) begin
                skip_q <= 1'b1;
                done_q <= 1'b1;
              end
            end else if (fall_i && cnt_q == 4'd8) begin
              cnt_q   <= '0;
              state_q <= ST_WACK;
              pull_q  <= 1'b1;
            end
          end
          ST_WACK: if (fall_i) begin
            pull_q  <= 1'b0;
            skip_q  <= 1'b0;
            state_q <= skip_q ? ST_WSKIP : ST_WDAT;
          end
          ST_WSKIP: if (fall_i) state_q <= ST_WDAT;
          ST_RDAT: begin
            if (rise_i) begin
              sreg_q <= {sreg_q[REG_BITS-2:0], sreg_q[REG_BITS-1]};
              cnt_q  <= cnt_q + 4'd1;
            end else if (fall_i) begin
              if (cnt_q == 4'd8) begin
                cnt_q   <= '0;
                pull_q  <= 1'b0;
                state_q <= ST_RGAP;
              end else begin
                pull_q <= ~sreg_q[REG_BITS-1];
              end
            end
          end
          ST_RGAP: begin
            if (rise_i && sda_i) state_q <= ST_IDLE;  // controller declined more
            else if (fall_i) begin
              state_q <= ST_RDAT;
              pull_q  <= ~sreg_q[REG_BITS-1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pull_o = pull_q;
  assign done_o = done_q;
  assign sreg_o = sreg_q;

  a_r11_quiet_idle_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_ADDR) |-> !pull_q);
  a_r5_pull_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pull_q) |-> ($past(fall_i) || $past(start_i) || $past(stop_i)));
  a_r5_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WACK |-> pull_q);
  a_r10_gap_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RGAP |-> !pull_q);
  a_r8_skip_keeps_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_WSKIP && !$past(start_i) && !$past(stop_i)) |-> $stable(sreg_q));
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
  parameter int REG_BITS = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                latch_en_i,
  input  logic                scl_i,
  input  logic                done_i,
  input  logic [REG_BITS-1:0] sreg_i,
  output logic [REG_BITS-1:0] disp_o
);
  logic en_q, load;

  assign load = (done_i & latch_en_i) | (latch_en_i & ~en_q & scl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      disp_o <= '0;
    end else begin
      en_q <= latch_en_i;
      if (load) disp_o <= sreg_i;
    end
  end

  a_r7_hold_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!latch_en_i) |-> $stable(disp_o));
endmodule

// File: rtl/lcd_seg_port.sv
module lcd_seg_port #(
  parameter int REG_BITS = 128,
  parameter logic [3:0] ADDR_FIXED = 4'b0111
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [2:0]          strap_i,
  input  logic                latch_en_i,
  output logic                sda_pull_o,
  output logic [REG_BITS-1:0] shift_o,
  output logic [REG_BITS-1:0] disp_o
);
  logic rise, fall, start, stop, done;

  lcd_seg_bus_sense u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .rise_o(rise), .fall_o(fall), .start_o(start), .stop_o(stop)
  );

  lcd_seg_engine #(.REG_BITS(REG_BITS), .ADDR_FIXED(ADDR_FIXED)) u_engine (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .start_i(start), .stop_i(stop),
    .sda_i, .strap_i, .pull_o(sda_pull_o), .done_o(done), .sreg_o(shift_o)
  );

  lcd_seg_latch #(.REG_BITS(REG_BITS)) u_latch (
    .clk_i, .rst_ni, .latch_en_i, .scl_i, .done_i(done), .sreg_i(shift_o), .disp_o
  );
endmodule

// File: tb/lcd_seg_port_test.sv
module lcd_seg_port_test;
  localparam int RB = 128;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_c = 1'b1, sda_c = 1'b1, len = 1'b1;
  logic [2:0] strap = 3'b101;
  logic pull;
  logic [RB-1:0] shift, disp;
  logic sda_line;
  logic [RB-1:0] exp_r, exp_d;
  int n_run = 0, n_fail = 0;
  bit done_f = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_c & ~pull;

  lcd_seg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_c), .sda_i(sda_line), .strap_i(strap),
    .latch_en_i(len), .sda_pull_o(pull), .shift_o(shift), .disp_o(disp)
  );

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [RB-1:0] act, logic [RB-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_f) begin
      done_f = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic clk_bit(input logic b, output logic line, output logic pl);
    sda_c = b; w(3);
    scl_c = 1'b1; w(3);
    line = sda_line; pl = pull;
    w(1); scl_c = 1'b0; w(3);
  endtask

  task automatic do_start();
    sda_c = 1'b1; w(2); scl_c = 1'b1; w(3);
    sda_c = 1'b0; w(3); scl_c = 1'b0; w(3);
  endtask

  task automatic do_stop();
    sda_c = 1'b0; w(3); scl_c = 1'b1; w(3);
    sda_c = 1'b1; w(4);
  endtask

  function automatic void push(logic b);
    exp_r = {exp_r[RB-2:0], b};
  endfunction

  // sends a byte plus ninth clock; returns pull seen on ninth clock
  task automatic wbyte(input logic [7:0] v, input bit model, output logic ack);
    logic l, p;
    for (int j = 7; j >= 0; j--) begin
      clk_bit(v[j], l, p);
      if (model) push(v[j]);
    end
    clk_bit(1'b1, l, ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_up();
  end

  initial begin
    logic a, l, p;
    exp_r = '0; exp_d = '0;
    w(3); rst_n = 1'b1; w(3);
    // R1 reset
    chk("R1 shift", shift, '0);
    chk("R1 disp", disp, '0);
    chk("R1 pull", RB'(pull), '0);

    // write block with automatic latch
    do_start();
    chk("R11 start", RB'(pull), '0);
    wbyte(8'b0111_101_0, 0, a);
    chk("R3 ack match", RB'(a), RB'(1));
    for (int i = 0; i < 16; i++) begin
      wbyte(8'(i * 29 + 7), 1, a);
      chk("R5 byte ack", RB'(a), RB'(1));
      chk("R5 ack released", RB'(pull), '0);
      if (i == 14) chk("R6 no early latch", disp, '0);
    end
    chk("R4 block contents", shift, exp_r);
    chk("R6 auto latch", disp, exp_r);
    exp_d = exp_r;
    // R8 skipped clock, then another byte
    clk_bit(1'b0, l, p);
    chk("R8 skip clock no shift", shift, exp_r);
    wbyte(8'hA5, 1, a);
    chk("R8 resume byte", shift, exp_r);
    chk("R8 ack after skip", RB'(a), RB'(1));
    do_stop(); push(1'b0);  // stop's clock rise shifts a 0
    chk("R2 stop", RB'(pull), '0);

    // R3 wrong address ignored
    do_start();
    wbyte(8'b0111_100_0, 0, a);
    chk("R3 no ack", RB'(a), '0);
    wbyte(8'h00, 0, a);
    chk("R3 bits ignored", shift, exp_r);
    chk("R11 idle quiet", RB'(a), '0);
    do_stop();

    // R7 manual latch
    len = 1'b0;
    do_start();
    wbyte(8'b0111_101_0, 0, a);
    for (int i = 0; i < 16; i++) wbyte(8'(i * 53 + 11), 1, a);
    do_stop();  // in skip clock: nothing shifted
    chk("R7 no auto latch", disp, exp_d);
    chk("R8 stop in skip", shift, exp_r);
    len = 1'b1; w(3);
    chk("R7 manual latch", disp, exp_r);

    // R9/R10 readback
    do_start();
    wbyte(8'b0111_101_1, 0, a);
    chk("R3 read ack", RB'(a), RB'(1));
    for (int i = 0; i < 16; i++) begin
      logic [7:0] got;
      for (int j = 0; j < 8; j++) begin
        clk_bit(1'b1, l, p);
        got[7-j] = l;
      end
      chk("R9 read byte", RB'(got), RB'(exp_r[RB-1-8*i -: 8]));
      clk_bit(i == 15, l, p);
      chk("R10 ninth released", RB'(p), '0);
    end
    w(2);
    chk("R10 nack releases", RB'(pull), '0);
    do_stop();
    chk("R9 register intact", shift, exp_r);

    // R2 repeated start mid-byte
    do_start();
    wbyte(8'b0111_101_0, 0, a);
    clk_bit(1'b1, l, p); push(1'b1);
    clk_bit(1'b0, l, p); push(1'b0);
    clk_bit(1'b1, l, p); push(1'b1);
    do_start(); push(1'b1);  // repeated start's clock rise shifts a 1
    wbyte(8'b0111_101_0, 0, a);
    chk("R2 restart address ack", RB'(a), RB'(1));
    wbyte(8'h3C, 1, a);
    chk("R2 after restart", shift, exp_r);
    do_stop(); push(1'b0);
    chk("R4 stop bit", shift, exp_r);

    // R3 sweep of all 7-bit addresses
    for (int ad = 0; ad < 128; ad++) begin
      do_start();
      wbyte({7'(ad), 1'b0}, 0, a);
      chk("R3 sweep", RB'(a), RB'(ad == {4'b0111, strap}));
      do_stop();
    end
    finish_up();
  end
endmodule